// File: doc/BRIEF.md
# LCD Driver Command Interpreter

This block sits behind a serial receiver in a dot-matrix LCD controller. It takes control bytes one at a time, each qualified by a valid strobe, along with a marker that flags the first byte of a frame. While it is in command mode, it sorts every byte into one of five command kinds, using a prefix code in the low seven bits. It then writes the immediate field of that byte into the matching configuration register. Every configuration register drives an output: multiplex mode, display status, system type, start bank, subaddress, RAM access mode, column pointer and Y pointer.

Bit 7 of a command byte chains commands. When it is set, the next byte is also a command. When it is clear, every later byte of the frame is display data. Data bytes are passed out on a data strobe and are never decoded. A column value outside the display raises a one-cycle error pulse, and the column pointer keeps its old value. The reset input is asserted asynchronously, and the block leaves reset synchronously two clocks after the input is released.

Top module: `lcd_cmd_interp`

## Requirements
- R1: After reset every configuration output reads zero. That means display status 00 (blank), multiplex code 00 (1:32), column pointer 0, Y pointer 0, subaddress 0, start bank 0, access mode 0 (character) and system type 0 (row only). In addition, cmd_mode is 1, and data_valid and x_err are 0.
- R2: A command byte whose bit 6 is 0 loads the column pointer. When bits 5..0 hold a value from 0 to 39, that value becomes x_ptr.
- R3: A column load whose value is 40 to 63 leaves x_ptr unchanged. It sets x_err to 1 for exactly one cycle, in the same cycle where a legal load would have shown.
- R4: A command byte with bits 6..5 = 10 loads three fields. Bit 4 goes to sys_type (0 row only, 1 mixed), bits 3..2 go to disp_status (00 blank, 01 normal, 10 all on, 11 inverse) and bits 1..0 go to mux_mode (01 1:8, 10 1:16, 11 1:24, 00 1:32).
- R5: A command byte with bits 6..4 = 110 loads bits 3..0 into subaddr.
- R6: A command byte with bits 6..2 = 11111 loads bits 1..0 into start_bank. This pattern never changes access_mode or y_ptr.
- R7: A command byte with bits 6..4 = 111 and bits 3..2 other than 11 loads two fields. Bits 3..2 go to access_mode (00 character, 01 half-graphic, 10 full-graphic) and bits 1..0 go to y_ptr.
- R8: A command byte with bit 7 = 1 keeps cmd_mode at 1. With bit 7 = 0 it sets cmd_mode to 0. After that, each valid byte shows on data_byte with data_valid high for one cycle, and no configuration output changes.
- R9: A frame_start pulse sets cmd_mode to 1 and changes no configuration output. A byte that is valid in the same cycle as frame_start is decoded as a command.
- R10: An update shows on the outputs one clock after the edge that samples its valid strobe. With byte_valid low, no configuration output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the start of a frame |
| byte_valid | input | 1 | byte_in holds a received byte |
| byte_in | input | 8 | Received byte |
| mux_mode | output | 2 | Multiplex mode code |
| disp_status | output | 2 | Display status code |
| sys_type | output | 1 | System type |
| start_bank | output | 2 | Bank shown at the top of the display |
| subaddr | output | 4 | Hardware subaddress |
| access_mode | output | 2 | RAM access mode |
| x_ptr | output | 6 | Column pointer |
| y_ptr | output | 2 | Y pointer |
| cmd_mode | output | 1 | 1 when the next byte is a command |
| data_valid | output | 1 | One-cycle strobe for a display data byte |
| data_byte | output | 8 | Display data byte |
| x_err | output | 1 | One-cycle pulse for an out-of-range column |

## Verification
Some properties are checked on every cycle. The column pointer never holds a value above 39, and an error pulse never comes with a pointer change. Configuration stays still in any cycle that follows a cycle with no strobe. Data strobes appear only after a data-mode cycle, and a bare frame start always returns the block to command mode. Only the bench scenarios can show the rest: the exact field placement for each command kind, the priority of the bank pattern over access code 11, and the one-cycle timing of every update compared against a reference model.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int XPTR_W = 6;

  typedef enum logic [2:0] {
    K_LDX    = 3'd0,
    K_MODE   = 3'd1,
    K_DEVSEL = 3'd2,
    K_BANK   = 3'd3,
    K_RAM    = 3'd4
  } cmd_kind_e;

  typedef struct packed {
    logic              sys_type;
    logic [1:0]        disp_status;
    logic [1:0]        mux_mode;
    logic [1:0]        start_bank;
    logic [3:0]        subaddr;
    logic [1:0]        access_mode;
    logic [XPTR_W-1:0] x_ptr;
    logic [1:0]        y_ptr;
  } cfg_t;
endpackage

// File: rtl/lcdc_rst_sync.sv
module lcdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
#(
  parameter int X_COLS = 40
) (
  input  logic [6:0]  op,
  output cmd_kind_e   kind,
  output logic        x_ok
);
  localparam logic [XPTR_W-1:0] X_LAST = XPTR_W'(X_COLS - 1);

  always_comb begin
    if (!op[6])                 kind = K_LDX;
    else if (!op[5])            kind = K_MODE;
    else if (!op[4])            kind = K_DEVSEL;
    else if (op[3:2] == 2'b11)  kind = K_BANK;   // bank wins over access code 11
    else                        kind = K_RAM;
  end

  assign x_ok = (op[XPTR_W-1:0] <= X_LAST);
endmodule

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cmd_kind_e  kind,
  input  logic [6:0] op,
  input  logic       x_ok,
  output cfg_t       cfg,
  output logic       x_err
);
  cfg_t cfg_q, cfg_d;
  logic err_q, err_d;

  always_comb begin
    cfg_d = cfg_q;
    err_d = 1'b0;
    if (wr_en) begin
      unique case (kind)
        K_LDX: begin
          if (x_ok) cfg_d.x_ptr = op[XPTR_W-1:0];
          else      err_d       = 1'b1;
        end
        K_MODE: begin
          cfg_d.sys_type    = op[4];
          cfg_d.disp_status = op[3:2];
          cfg_d.mux_mode    = op[1:0];
        end
        K_DEVSEL: cfg_d.subaddr    = op[3:0];
        K_BANK:   cfg_d.start_bank = op[1:0];
        K_RAM: begin
          cfg_d.access_mode = op[3:2];
          cfg_d.y_ptr       = op[1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg   = cfg_q;
  assign x_err = err_q;
endmodule

// File: rtl/lcdc_stream_ctl.sv
module lcdc_stream_ctl #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              cmd_wr,
  output logic              cmd_mode,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_byte
);
  logic              mode_q, mode_d;
  logic              dv_q, dv_d;
  logic [BYTE_W-1:0] db_q;
  logic              is_cmd, db_en;

  assign is_cmd = mode_q | frame_start;
  assign cmd_wr = byte_valid & is_cmd;
  assign db_en  = byte_valid & ~is_cmd;

  always_comb begin
    mode_d = mode_q;
    if (frame_start) mode_d = 1'b1;
    if (cmd_wr)      mode_d = byte_in[BYTE_W-1];
    dv_d = db_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      dv_q   <= 1'b0;
      db_q   <= '0;
    end else begin
      mode_q <= mode_d;
      dv_q   <= dv_d;
      if (db_en) db_q <= byte_in;
    end
  end

  assign cmd_mode   = mode_q;
  assign data_valid = dv_q;
  assign data_byte  = db_q;
endmodule

// File: rtl/lcd_cmd_interp.sv
module lcd_cmd_interp
  import lcdc_pkg::*;
#(
  parameter int X_COLS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  output logic [1:0]        mux_mode,
  output logic [1:0]        disp_status,
  output logic              sys_type,
  output logic [1:0]        start_bank,
  output logic [3:0]        subaddr,
  output logic [1:0]        access_mode,
  output logic [XPTR_W-1:0] x_ptr,
  output logic [1:0]        y_ptr,
  output logic              cmd_mode,
  output logic              data_valid,
  output logic [7:0]        data_byte,
  output logic              x_err
);
  logic      rst_n_s;
  logic      cmd_wr;
  cmd_kind_e kind;
  logic      x_ok;
  cfg_t      cfg;

  lcdc_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  lcdc_stream_ctl #(.BYTE_W(8)) i_ctl (
    .clk(clk), .rst_n(rst_n_s), .frame_start(frame_start),
    .byte_valid(byte_valid), .byte_in(byte_in), .cmd_wr(cmd_wr),
    .cmd_mode(cmd_mode), .data_valid(data_valid), .data_byte(data_byte)
  );

  lcdc_decode #(.X_COLS(X_COLS)) i_dec (
    .op(byte_in[6:0]), .kind(kind), .x_ok(x_ok)
  );

  lcdc_cfg_regs i_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(cmd_wr), .kind(kind),
    .op(byte_in[6:0]), .x_ok(x_ok), .cfg(cfg), .x_err(x_err)
  );

  assign mux_mode    = cfg.mux_mode;
  assign disp_status = cfg.disp_status;
  assign sys_type    = cfg.sys_type;
  assign start_bank  = cfg.start_bank;
  assign subaddr     = cfg.subaddr;
  assign access_mode = cfg.access_mode;
  assign x_ptr       = cfg.x_ptr;
  assign y_ptr       = cfg.y_ptr;
endmodule

// File: rtl/lcdc_checker.sv
module lcdc_checker #(
  parameter int X_COLS = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        byte_valid,
  input logic        cmd_mode,
  input logic        data_valid,
  input logic        x_err,
  input logic [5:0]  x_ptr,
  input logic [20:0] cfg_flat
);
  AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(x_ptr) < X_COLS);  // R2
  AST_ERR_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    x_err |-> $stable(x_ptr));  // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_valid) |-> $stable(cfg_flat));  // R10
  AST_DATA_AFTER_DATA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !$past(cmd_mode));  // R8
  AST_FRAME_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start && !byte_valid) |-> cmd_mode);  // R9
endmodule

bind lcd_cmd_interp lcdc_checker #(.X_COLS(X_COLS)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
  .cmd_mode(cmd_mode), .data_valid(data_valid), .x_err(x_err), .x_ptr(x_ptr),
  .cfg_flat({sys_type, disp_status, mux_mode, start_bank, subaddr,
             access_mode, x_ptr, y_ptr})
);

// File: tb/test_lcd_cmd_interp.sv
module test_lcd_cmd_interp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, frame_start, byte_valid;
  logic [7:0] byte_in;
  logic [1:0] mux_mode, disp_status, start_bank, access_mode, y_ptr;
  logic sys_type, cmd_mode, data_valid, x_err;
  logic [3:0] subaddr;
  logic [5:0] x_ptr;
  logic [7:0] data_byte;

  int vectors = 0;
  int fails   = 0;

  // reference model state
  logic [20:0] m_cfg;   // {sys,disp,mux,bank,sub,acc,x,y}
  logic m_cmd, m_dv, m_err;
  logic [7:0] m_db;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmd_interp i_lcd_cmd_interp (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_in(byte_in), .mux_mode(mux_mode), .disp_status(disp_status),
    .sys_type(sys_type), .start_bank(start_bank), .subaddr(subaddr),
    .access_mode(access_mode), .x_ptr(x_ptr), .y_ptr(y_ptr), .cmd_mode(cmd_mode),
    .data_valid(data_valid), .data_byte(data_byte), .x_err(x_err)
  );

  function automatic string tag_of(input logic [7:0] b, input logic as_cmd);
    if (!as_cmd)               return "R8";
    if (!b[6])                 return (b[5:0] > 6'd39) ? "R3" : "R2";
    if (!b[5])                 return "R4";
    if (!b[4])                 return "R5";
    if (b[3:2] == 2'b11)       return "R6";
    return "R7";
  endfunction

  // update the model for one byte per the requirements
  function automatic void model_byte(input logic [7:0] b);
    m_err = 1'b0;
    m_dv  = 1'b0;
    if (m_cmd) begin
      if (!b[6]) begin
        if (b[5:0] <= 6'd39) m_cfg[7:2] = b[5:0];
        else                 m_err = 1'b1;
      end else if (!b[5]) begin
        m_cfg[20] = b[4]; m_cfg[19:18] = b[3:2]; m_cfg[17:16] = b[1:0];
      end else if (!b[4]) begin
        m_cfg[13:10] = b[3:0];
      end else if (b[3:2] == 2'b11) begin
        m_cfg[15:14] = b[1:0];
      end else begin
        m_cfg[9:8] = b[3:2]; m_cfg[1:0] = b[1:0];
      end
      m_cmd = b[7];
    end else begin
      m_dv = 1'b1;
      m_db = b;
    end
  endfunction

  task automatic check(input string tag);
    logic [20:0] act;
    act = {sys_type, disp_status, mux_mode, start_bank, subaddr, access_mode, x_ptr, y_ptr};
    vectors++;
    if (act !== m_cfg || cmd_mode !== m_cmd || data_valid !== m_dv || x_err !== m_err ||
        (m_dv && data_byte !== m_db)) begin
      fails++;
      $display("FAIL %s: cfg=%h cmd=%b dv=%b err=%b db=%h expected cfg=%h cmd=%b dv=%b err=%b db=%h",
               tag, act, cmd_mode, data_valid, x_err, data_byte,
               m_cfg, m_cmd, m_dv, m_err, m_db);
    end
  endtask

  // called at a falling edge; drives one byte, checks at the next falling edge
  task automatic send(input logic [7:0] b, input logic fs);
    logic as_cmd;
    if (fs) m_cmd = 1'b1;
    as_cmd = m_cmd;
    frame_start = fs; byte_valid = 1'b1; byte_in = b;
    model_byte(b);
    @(negedge clk);
    frame_start = 1'b0; byte_valid = 1'b0;
    check(tag_of(b, as_cmd));
  endtask

  task automatic idle(input logic fs, input string tag);
    frame_start = fs; byte_valid = 1'b0; byte_in = $urandom;
    if (fs) m_cmd = 1'b1;
    m_dv = 1'b0; m_err = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    rst_n = 1'b0; frame_start = 1'b0; byte_valid = 1'b0; byte_in = '0;
    m_cfg = '0; m_cmd = 1'b1; m_dv = 1'b0; m_err = 1'b0; m_db = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");

    // R2 / R3 column boundary
    send(8'h80 | 8'd39, 1'b1);
    send(8'h80 | 8'd40, 1'b0);
    idle(1'b0, "R3");            // error pulse lasts one cycle
    send(8'h80 | 8'd63, 1'b0);
    send(8'h80 | 8'd0,  1'b0);
    // R4 mode fields
    send(8'hC0 | 8'h1B, 1'b0);
    send(8'hC0 | 8'h04, 1'b0);
    // R5 subaddress
    send(8'hEA, 1'b0);
    // R6 bank pattern, all four, priority over access code 11
    for (int i = 0; i < 4; i++) send(8'hFC | 8'(i), 1'b0);
    // R7 access modes
    send(8'hF3, 1'b0);
    send(8'hF6, 1'b0);
    send(8'hF9, 1'b0);
    // R8 end of commands, then data bytes do not decode
    send(8'h45, 1'b0);
    send(8'h7F, 1'b0);
    send(8'h20, 1'b0);
    idle(1'b0, "R10");
    // R9 bare frame start, then a command
    idle(1'b1, "R9");
    send(8'h8A, 1'b0);
    // R9 frame start with byte in same cycle while in data mode
    send(8'h12, 1'b0);
    send(8'h55, 1'b0);
    send(8'h7D, 1'b1);

    // constrained random frames
    for (int n = 0; n < 600; n++) begin
      logic [7:0] b;
      int r;
      b = 8'($urandom);
      r = int'($urandom % 16);
      if (r == 0)      idle(1'b1, "R9");
      else if (r == 1) idle(1'b0, "R10");
      else             send(b, (r == 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule